// File: doc/BRIEF.md
# Dual-Band Multimodulus Prescaler

This block divides its input clock by one of four ratios: 32, 33, 47 or 48. It produces one output pulse per division period, and that pulse clocks the downstream swallow and program counters of an integer-N divider. A band-select input chooses between the low pair, 32/33, and the high pair, 47/48. A modulus-control input then chooses the smaller ratio N or the larger ratio N+1 within the selected pair.

Internally, a 2/3 stage produces sub-periods that are 2 or 3 input cycles long. A divide-by-16 chain counts these sub-periods. Each period therefore lasts 32 input cycles plus one extra cycle for every sub-period that runs in divide-by-3.

- In the low band, divide-by-3 is the exception: at most the final sub-period stretches. For ratio 33, the steering signal keeps the stage in divide-by-2 for the first 30 input cycles and selects divide-by-3 for the last 3.
- In the high band the steering is the complement of the low band: divide-by-2 is the exception. Every sub-period stretches for ratio 48, and all but the final one stretch for ratio 47.

The two configuration inputs are captured only on the last cycle of a period and while reset is asserted. A change on them never shortens or lengthens the period in progress.

Top module: `dbp_prescaler`

## Requirements
- R1: With band select low and modulus control high, every division period is exactly 32 input cycles long.
- R2: With band select low and modulus control low, every period is 33 input cycles, and the single divide-by-3 sub-period is the last of the 16.
- R3: With band select high and modulus control low, every period is 48 input cycles, with all 16 sub-periods in divide-by-3.
- R4: With band select high and modulus control high, every period is 47 input cycles, with exactly one sub-period (the last) in divide-by-2.
- R5: Band select and modulus control are sampled only at the edge that ends a period. A change in any earlier cycle leaves the current period at the old ratio, and the next period uses the new ratio.
- R6: A synchronous active-high reset clears all counters and captures the configuration. The pulse is low in the cycle after a reset edge, and the first pulse appears exactly one full period after reset is released, even when reset arrives mid-period.
- R7: The output pulse is high for exactly one input cycle, the last cycle of each period, and is low in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| band_hi_i | input | 1 | 0 selects the 32/33 pair, 1 selects the 47/48 pair |
| mod_n_i | input | 1 | 1 selects ratio N (32 or 47), 0 selects N+1 (33 or 48) |
| pulse_o | output | 1 | One-cycle pulse on the last input cycle of each period |

## Verification
The bench measures every period length in all four configurations. It also runs all sixteen ordered pairs of old and new configuration with the change made mid-period. A design that sampled the inputs continuously would produce a hybrid period length instead of the old ratio followed by the new one. A change presented on the pulse cycle itself must already take effect in the next period. A late capture would leave one stale period.

A reset issued mid-period must yield a full first period. A counter left uncleared would produce a short first pulse. In the high band, divide-by-2 is the exception. A design that steered the stage without the complement would swap 47 and 48, and the per-configuration checks catch this.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  typedef struct packed {
    logic band_hi;
    logic mod_n;
  } dbp_cfg_t;

  // Low band: divide-by-3 only on the last sub-period, and only for N+1.
  // High band: complement; divide-by-2 only on the last sub-period, and only for N.
  function automatic logic pick_three(dbp_cfg_t c, logic last_sub);
    if (c.band_hi) return ~(last_sub & c.mod_n);
    return last_sub & ~c.mod_n;
  endfunction

  function automatic int period_len(dbp_cfg_t c, int subs);
    int threes;
    if (c.band_hi) threes = c.mod_n ? subs - 1 : subs;
    else           threes = c.mod_n ? 0 : 1;
    return 2 * subs + threes;
  endfunction

endpackage

// File: rtl/dbp_stage23.sv
module dbp_stage23 (
  input  logic clk_i,
  input  logic rst_i,
  input  logic take_three_i,
  output logic sub_end_o
);
  logic [1:0] ph_q;

  assign sub_end_o = take_three_i ? (ph_q == 2'd2) : (ph_q == 2'd1);

  always_ff @(posedge clk_i) begin
    if (rst_i)          ph_q <= 2'd0;
    else if (sub_end_o) ph_q <= 2'd0;
    else                ph_q <= ph_q + 2'd1;
  end

  // R1: sub-periods last two or three cycles, never more
  p_phase_max_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    ph_q != 2'd3);
  p_two_cycle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (ph_q == 2'd1 && !take_three_i) |=> (ph_q == 2'd0));
endmodule

// File: rtl/dbp_subchain.sv
module dbp_subchain #(
  parameter int SUB_BITS = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sub_end_i,
  output logic last_sub_o,
  output logic wrap_o
);
  logic [SUB_BITS-1:0] sub_q;

  assign last_sub_o = &sub_q;
  assign wrap_o     = sub_end_i & last_sub_o;

  always_ff @(posedge clk_i) begin
    if (rst_i)          sub_q <= '0;
    else if (sub_end_i) sub_q <= sub_q + 1'b1;
  end

  // R1: the chain only moves at a sub-period boundary
  p_sub_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !sub_end_i |=> $stable(sub_q));
  // R7: after the period ends the chain restarts at zero
  p_sub_wrap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> (sub_q == '0));
endmodule

// File: rtl/dbp_modctl.sv
module dbp_modctl
  import dbp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     band_hi_i,
  input  logic     mod_n_i,
  input  logic     wrap_i,
  input  logic     last_sub_i,
  output dbp_cfg_t cfg_o,
  output logic     take_three_o
);
  dbp_cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || wrap_i) cfg_q <= '{band_hi: band_hi_i, mod_n: mod_n_i};
  end

  assign cfg_o        = cfg_q;
  assign take_three_o = pick_three(cfg_q, last_sub_i);

  // R5: configuration is frozen inside a period
  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_i |=> $stable(cfg_q));
  p_low_n_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cfg_q.band_hi && cfg_q.mod_n) |-> !take_three_o);
  p_low_np1_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cfg_q.band_hi && !cfg_q.mod_n && take_three_o) |-> last_sub_i);
  p_high_np1_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_q.band_hi && !cfg_q.mod_n) |-> take_three_o);
  p_high_n_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_q.band_hi && cfg_q.mod_n && !take_three_o) |-> last_sub_i);
endmodule

// File: rtl/dbp_prescaler.sv
module dbp_prescaler
  import dbp_pkg::*;
#(
  parameter int SUB_BITS = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic band_hi_i,
  input  logic mod_n_i,
  output logic pulse_o
);
  localparam int SUBS  = 1 << SUB_BITS;
  localparam int CYC_W = $clog2(3 * SUBS + 1);

  logic     take_three, sub_end, last_sub, wrap;
  dbp_cfg_t cfg;

  dbp_stage23 u_stage (
    .clk_i(clk_i), .rst_i(rst_i),
    .take_three_i(take_three), .sub_end_o(sub_end)
  );

  dbp_subchain #(.SUB_BITS(SUB_BITS)) u_chain (
    .clk_i(clk_i), .rst_i(rst_i), .sub_end_i(sub_end),
    .last_sub_o(last_sub), .wrap_o(wrap)
  );

  dbp_modctl u_ctl (
    .clk_i(clk_i), .rst_i(rst_i),
    .band_hi_i(band_hi_i), .mod_n_i(mod_n_i),
    .wrap_i(wrap), .last_sub_i(last_sub),
    .cfg_o(cfg), .take_three_o(take_three)
  );

  assign pulse_o = wrap;

  // Independent cycle count per period, used only by the checks below.
  logic [CYC_W-1:0] cyc_q;
  always_ff @(posedge clk_i) begin
    if (rst_i || wrap) cyc_q <= CYC_W'(1);
    else               cyc_q <= cyc_q + 1'b1;
  end

  // R1 R2 R3 R4: period length matches the captured configuration
  p_period_len_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap |-> (int'(cyc_q) == period_len(cfg, SUBS)));
  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);
  p_reset_quiet_r6: assert property (@(posedge clk_i)
    rst_i |=> !pulse_o);
endmodule

// File: tb/tb_dbp_prescaler.sv
module tb_dbp_prescaler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic band = 1'b0;
  logic modn = 1'b1;
  logic pulse;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dbp_prescaler dut (
    .clk_i(clk), .rst_i(rst), .band_hi_i(band), .mod_n_i(modn), .pulse_o(pulse)
  );

  function automatic int want(logic b, logic m);
    if (b) return m ? 47 : 48;
    return m ? 32 : 33;
  endfunction

  function automatic string tag(logic b, logic m);
    if (b) return m ? "R4" : "R3";
    return m ? "R1" : "R2";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge showing cycle 1 of a period; returns the cycle of the pulse.
  task automatic gap(input int chg_at, input logic nb, input logic nm, output int n);
    n = 0;
    forever begin
      n++;
      if (n == chg_at) begin band = nb; modn = nm; end
      if (pulse) break;
      if (n >= 300) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic b, input logic m);
    @(negedge clk);
    band = b; modn = m; rst = 1'b1;
    @(negedge clk);
    check("R6", int'(pulse), 0);
    rst = 1'b0;
  endtask

  // After a pulse: the next cycle must be low (R7).
  task automatic after_pulse();
    @(negedge clk);
    check("R7", int'(pulse), 0);
  endtask

  initial begin
    int n;
    rst = 1'b1;
    repeat (3) @(negedge clk);

    // Steady ratios in all four configurations.
    for (int c = 0; c < 4; c++) begin
      logic b, m;
      b = c[1]; m = c[0];
      do_reset(b, m);
      gap(0, b, m, n);
      check("R6", n, want(b, m));
      for (int p = 0; p < 3; p++) begin
        after_pulse();
        gap(0, b, m, n);
        check(tag(b, m), n, want(b, m));
      end
    end

    // Mid-period changes across every ordered pair of configurations.
    for (int c = 0; c < 16; c++) begin
      logic ob, om, nb, nm;
      ob = c[3]; om = c[2]; nb = c[1]; nm = c[0];
      do_reset(ob, om);
      gap(0, ob, om, n);
      after_pulse();
      gap(7, nb, nm, n);
      check("R5", n, want(ob, om));
      after_pulse();
      gap(0, nb, nm, n);
      check("R5", n, want(nb, nm));
    end

    // Change presented on the pulse cycle takes effect at once.
    do_reset(1'b0, 1'b1);
    gap(0, 1'b0, 1'b1, n);
    after_pulse();
    gap(32, 1'b1, 1'b0, n);
    check("R5", n, 32);
    after_pulse();
    gap(0, 1'b1, 1'b0, n);
    check("R5", n, 48);

    // Reset in the middle of a period restarts cleanly.
    do_reset(1'b1, 1'b1);
    repeat (11) @(negedge clk);
    do_reset(1'b0, 1'b0);
    gap(0, 1'b0, 1'b0, n);
    check("R6", n, 33);
    after_pulse();
    gap(0, 1'b0, 1'b0, n);
    check("R2", n, 33);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule